// File: doc/BRIEF.md
# Stereo Soft-Ramp Digital Attenuator

This block scales a stereo stream of 16-bit two's complement samples by a linear gain coefficient. The coefficient is never changed in one jump. It follows a target value at a fixed slope, so that a sweep across the whole range from unity to silence takes 1024 sample periods. The target comes from a programmed 7-bit attenuation code. An active soft-mute request overrides the code and forces the target to zero.

The coefficient is an integer from 0 to 128, where 128 means unity. A new code can be loaded at any time. While the coefficient is still moving, it turns toward the new target from the value it holds at that moment. Each scaled sample is registered on the sample strobe. A flag marks the cycles in which the coefficient is zero.

Top module: `soft_atten`

## Requirements
- R1: For a programmed code c from 0x01 to 0x7E, a settled output equals floor(sample × c / 128). The sample is 16-bit two's complement, and the truncation is toward minus infinity.
- R2: Code 0x7F settles to unity gain, so the output equals the input. Code 0x00 settles to zero gain, so the output is 0.
- R3: The coefficient (0..128) moves one unit toward its target on every 8th sample strobe while it differs from the target. It never passes the target, so a full sweep takes 1024 strobes. The step counter is cleared whenever the coefficient equals the target.
- R4: A code loaded while a ramp is in progress makes the coefficient head for the new target from its current value, without reset or jump.
- R5: While mute_i is high, the target is 0 and the coefficient ramps down at the R3 rate. A code loaded during mute is stored but does not move the coefficient. After mute_i falls, the coefficient ramps to the stored code's gain.
- R6: While rst_ni is low, the coefficient, left_o and right_o are 0. The programmed code returns to 0x7F, so after reset the gain ramps up from 0 to unity.
- R7: zero_o is high exactly when the current coefficient is 0. While it is high, a strobed sample produces an output of 0.
- R8: left_o and right_o change only on a cycle with smp_stb_i high. They use the coefficient as it stood before that strobe's clock edge, and they hold between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_stb_i | input | 1 | One-cycle strobe per stereo sample period |
| left_i | input | 16 | Left input sample, two's complement |
| right_i | input | 16 | Right input sample, two's complement |
| code_i | input | 7 | Attenuation code |
| code_ld_i | input | 1 | Stores code_i when high |
| mute_i | input | 1 | Soft-mute request, level sensitive |
| left_o | output | 16 | Scaled left sample |
| right_o | output | 16 | Scaled right sample |
| zero_o | output | 1 | High when the coefficient is zero |

## Verification
On every cycle, the assertions check the following:
- the coefficient stays within 0..128;
- the coefficient moves by at most one unit, only after a strobe, and never away from its target;
- during mute the coefficient only falls;
- the outputs hold between strobes;
- a zero coefficient yields zero outputs.

The bench scenarios alone can show the rest:
- the exact eight-strobe cadence;
- the arithmetic of each settled gain, including truncation of negative products;
- the reversal of direction mid-ramp;
- the code stored during mute taking effect on release;
- the code returning to unity after a reset.

// File: rtl/soft_atten_pkg.sv
package soft_atten_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;

  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_CODE_W   = 7;
  localparam int unsigned DEF_STEP_DIV = 8;
endpackage

// File: rtl/atten_target.sv
module atten_target #(
  parameter int unsigned CODE_W = 7,
  localparam int unsigned COEF_W = CODE_W + 1,
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_ld_i,
  input  logic              mute_i,
  output logic [COEF_W-1:0] target_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] code_q;
  logic [COEF_W-1:0] code_gain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        code_q <= CODE_MAX;
    else if (code_ld_i) code_q <= code_i;
  end

  // all-ones code maps to exact unity
  assign code_gain = (code_q == CODE_MAX) ? UNITY : {1'b0, code_q};
  assign target_o  = mute_i ? '0 : code_gain;
endmodule

// File: rtl/atten_ramp.sv
module atten_ramp
  import soft_atten_pkg::*;
#(
  parameter int unsigned COEF_W   = 8,
  parameter int unsigned STEP_DIV = 8,
  localparam int unsigned CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic [COEF_W-1:0] target_i,
  output logic [COEF_W-1:0] coef_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_DIV - 1);

  ramp_dir_e         dir;
  logic [CNT_W-1:0]  cnt_q;
  logic [COEF_W-1:0] coef_q;

  always_comb begin
    if (coef_q < target_i)      dir = RAMP_UP;
    else if (coef_q > target_i) dir = RAMP_DOWN;
    else                        dir = RAMP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      coef_q <= '0;
    end else if (dir == RAMP_HOLD) begin
      cnt_q <= '0;
    end else if (smp_stb_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        coef_q <= (dir == RAMP_UP) ? coef_q + 1'b1 : coef_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign coef_o = coef_q;
endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned FRAC_W = COEF_W - 1,
  localparam int unsigned PROD_W = DATA_W + COEF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [DATA_W-1:0] smp_o
);
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_sh;
  logic                     unused_bits;

  // coefficient is unsigned: zero-extend before signed multiply
  assign prod    = PROD_W'($signed(smp_i)) * PROD_W'($signed({1'b0, coef_i}));
  assign prod_sh = prod >>> FRAC_W;
  assign unused_bits = ^prod_sh[PROD_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        smp_o <= '0;
    else if (smp_stb_i) smp_o <= prod_sh[DATA_W-1:0];
  end
endmodule

// File: rtl/soft_atten.sv
module soft_atten
  import soft_atten_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned STEP_DIV = DEF_STEP_DIV,
  localparam int unsigned COEF_W  = CODE_W + 1,
  localparam int unsigned NUM_CH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_ld_i,
  input  logic              mute_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              zero_o
);
  logic [COEF_W-1:0] target;
  logic [COEF_W-1:0] coef;
  logic [DATA_W-1:0] ch_in  [NUM_CH];
  logic [DATA_W-1:0] ch_out [NUM_CH];

  atten_target #(.CODE_W(CODE_W)) u_target (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code_i),
    .code_ld_i (code_ld_i),
    .mute_i    (mute_i),
    .target_o  (target)
  );

  atten_ramp #(.COEF_W(COEF_W), .STEP_DIV(STEP_DIV)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_stb_i (smp_stb_i),
    .target_i  (target),
    .coef_o    (coef)
  );

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    atten_scale #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_scale (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_stb_i (smp_stb_i),
      .smp_i     (ch_in[g]),
      .coef_i    (coef),
      .smp_o     (ch_out[g])
    );
  end

  assign left_o  = ch_out[0];
  assign right_o = ch_out[1];
  assign zero_o  = (coef == '0);
endmodule

// File: rtl/soft_atten_chk.sv
module soft_atten_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_stb_i,
  input logic              mute_i,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic              zero_o,
  input logic [COEF_W-1:0] coef,
  input logic [COEF_W-1:0] target
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << (COEF_W - 1);

  AST_COEF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef <= UNITY); // R3

  AST_STEP_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef != $past(coef)) |-> (coef == $past(coef) + 1'b1 || coef + 1'b1 == $past(coef))); // R3

  AST_STEP_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef != $past(coef)) |-> $past(smp_stb_i)); // R3

  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef > $past(coef)) |-> ($past(coef) < $past(target))); // R3

  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef < $past(coef)) |-> ($past(coef) > $past(target))); // R4

  AST_MUTE_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mute_i) && coef != $past(coef)) |-> (coef < $past(coef))); // R5

  AST_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(zero_o) && $past(smp_stb_i)) |-> (left_o == '0 && right_o == '0)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(smp_stb_i) |-> ($stable(left_o) && $stable(right_o))); // R8
endmodule

bind soft_atten soft_atten_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_stb_i (smp_stb_i),
  .mute_i    (mute_i),
  .left_o    (left_o),
  .right_o   (right_o),
  .zero_o    (zero_o),
  .coef      (coef),
  .target    (target)
);

// File: tb/soft_atten_test.sv
module soft_atten_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_stb_i = 1'b0;
  logic [15:0] left_i = '0;
  logic [15:0] right_i = '0;
  logic [6:0]  code_i = '0;
  logic        code_ld_i = 1'b0;
  logic        mute_i = 1'b0;
  logic [15:0] left_o, right_o;
  logic        zero_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  soft_atten uut (
    .clk_i, .rst_ni, .smp_stb_i, .left_i, .right_i,
    .code_i, .code_ld_i, .mute_i, .left_o, .right_o, .zero_o
  );

  typedef struct packed {
    logic [6:0]  code;
    logic [15:0] l;
    logic [15:0] r;
    logic [15:0] el;
    logic [15:0] er;
    logic        ez;
  } vec_t;

  // settled gain per code; expected = floor(sample*gain/128)
  localparam vec_t VECS [6] = '{
    '{7'h7F, 16'h03E8, 16'h8000, 16'h03E8, 16'h8000, 1'b0},
    '{7'h40, 16'h03E9, 16'hFC17, 16'h01F4, 16'hFE0B, 1'b0},
    '{7'h01, 16'h7FFF, 16'h8000, 16'h00FF, 16'hFF00, 1'b0},
    '{7'h00, 16'h3039, 16'hFFFF, 16'h0000, 16'h0000, 1'b1},
    '{7'h7E, 16'hFFFF, 16'h7FFF, 16'hFFFF, 16'h7DFF, 1'b0},
    '{7'h11, 16'h012C, 16'hFED4, 16'h0027, 16'hFFD8, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk_i);
    smp_stb_i = 1'b1; left_i = l; right_i = r;
    @(negedge clk_i);
    smp_stb_i = 1'b0;
  endtask

  task automatic load(input logic [6:0] c);
    @(negedge clk_i);
    code_i = c; code_ld_i = 1'b1;
    @(negedge clk_i);
    code_ld_i = 1'b0;
  endtask

  task automatic settle();
    repeat (1100) strobe(16'h0000, 16'h0000);
  endtask

  // sample value 128 makes the output equal the coefficient used
  task automatic probe(input string req, input int exp);
    strobe(16'd128, 16'd128);
    check(req, left_o, 16'(exp));
    check(req, right_o, 16'(exp));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk_i);
    check("R6 left", left_o, 16'h0);
    check("R6 right", right_o, 16'h0);
    check("R7 zero in reset", {15'h0, zero_o}, 16'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3/R6/R7: ramp from 0 toward unity, one unit per 8 strobes
    for (int k = 1; k <= 1030; k++) begin
      strobe(16'd128, 16'd128);
      check("R3 ramp", left_o, 16'((k - 1) / 8 > 128 ? 128 : (k - 1) / 8));
      if (k == 7) check("R7 zero before step", {15'h0, zero_o}, 16'h1);
      if (k == 8) check("R7 zero after step", {15'h0, zero_o}, 16'h0);
    end

    // R1/R2/R8: settled gains from the vector table
    foreach (VECS[i]) begin
      load(VECS[i].code);
      settle();
      strobe(VECS[i].l, VECS[i].r);
      check("R1 R2 left", left_o, VECS[i].el);
      check("R1 R2 right", right_o, VECS[i].er);
      check("R7 flag", {15'h0, zero_o}, {15'h0, VECS[i].ez});
      @(negedge clk_i);
      left_i = ~VECS[i].l; right_i = 16'h1234;
      repeat (3) @(negedge clk_i);
      check("R8 hold", left_o, VECS[i].el);
      check("R8 hold", right_o, VECS[i].er);
    end

    // R4: reversal in mid-ramp
    load(7'h7F);
    settle();
    load(7'h40);
    repeat (128) strobe(16'h0, 16'h0);
    load(7'h7F);
    probe("R4 retarget start", 112);
    repeat (7) strobe(16'h0, 16'h0);
    probe("R4 retarget reversed", 113);

    // R5: soft mute
    settle();
    mute_i = 1'b1;
    repeat (512) strobe(16'h0, 16'h0);
    probe("R5 mute half", 64);
    repeat (600) strobe(16'h0, 16'h0);
    check("R5 R7 muted flag", {15'h0, zero_o}, 16'h1);
    load(7'h20);
    repeat (20) strobe(16'h0, 16'h0);
    probe("R5 load ignored while muted", 0);
    @(negedge clk_i);
    mute_i = 1'b0;
    repeat (128) strobe(16'h0, 16'h0);
    probe("R5 release mid", 16);
    repeat (300) strobe(16'h0, 16'h0);
    probe("R5 release settled", 32);

    // R6: reset in operation restores code to unity
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R6 async left", left_o, 16'h0);
    check("R6 async right", right_o, 16'h0);
    check("R6 R7 flag", {15'h0, zero_o}, 16'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    probe("R6 coef zero", 0);
    settle();
    probe("R6 code unity", 128);

    finish_run();
  end
endmodule